// File: doc/BRIEF.md
# Encoder event and compare unit

This block watches the state of a quadrature encoder interface (phase count, revolution count, rotation direction, the index pulse Z, the home input H and a strobe marking each counted encoder edge) and turns it into four sticky event flags: index seen, position match, home reached and motion watchdog expired. The counting itself happens elsewhere; this unit only qualifies events and routes them.

Each flag can independently raise the level interrupt, emit a one-cycle DMA request, emit a one-cycle trigger pulse, and request that the surrounding logic copy all of its counters into a read bank. Software can also ask for a read-bank load directly, and a separate snap input, when enabled, requests a copy into a snapshot bank. Flags are cleared by writing 1 to the matching clear bit.

Flag bit order on every four-bit vector (flags, clears, enables) is: bit 0 index, bit 1 position match, bit 2 home, bit 3 watchdog.

Top module: `enc_event_unit`

## Requirements
- R1: The position flag (bit 1) sets only on the cycle the match condition goes from false to true; the match condition is phase count equal to the 21-bit phase compare value, revolution count equal to the 32-bit revolution compare value, and direction equal to the wanted direction. A match that stays true does not set the flag again after it is cleared.
- R2: With `cmp_rev_off` high the revolution count is left out of the match; with `cmp_dir_off` high the direction is left out. Otherwise `cmp_dir` 0 demands positive rotation (`dir_in` 0) and 1 demands negative rotation (`dir_in` 1).
- R3: A rising edge on `z_in` sets the index flag (bit 0).
- R4: The home flag (bit 2) sets on an H edge gated by `home_arm`: bit 0 rising edge with direction 0, bit 1 rising edge with direction 1, bit 2 falling edge with direction 0, bit 3 falling edge with direction 1.
- R5: With `wdg_en` high and a non-zero limit L, the watchdog flag (bit 3) sets at the L-th consecutive clock edge without `edge_strobe`, and only once until an edge or a disable restarts the count; a limit of 0 never fires.
- R6: Flags hold until cleared by a 1 on the matching `flag_clr` bit; an event in the same cycle as a clear leaves the flag set.
- R7: `irq` is high whenever any flag is set together with its `irq_en` bit.
- R8: `dma_req` and `trig_out` each pulse for one cycle, the cycle after an event whose `dma_en` or `trig_en` bit is set.
- R9: `read_load` pulses for one cycle after `sw_read` is high or after an event whose `load_en` bit is set.
- R10: `snap_load` pulses for one cycle after a rising edge of `snap_in` while `snap_en` is high; with `snap_en` low the snap input has no effect.
- R11: While `rst` is high all flags and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_cnt | input | 21 | Phase count |
| rev_cnt | input | 32 | Revolution count |
| dir_in | input | 1 | Rotation direction, 0 positive |
| z_in | input | 1 | Index input |
| h_in | input | 1 | Home input |
| edge_strobe | input | 1 | High in a cycle with a counted encoder edge |
| snap_in | input | 1 | Snapshot request input |
| cmp_ph | input | 21 | Phase compare value |
| cmp_rev | input | 32 | Revolution compare value |
| cmp_rev_off | input | 1 | Leave revolution count out of the match |
| cmp_dir_off | input | 1 | Leave direction out of the match |
| cmp_dir | input | 1 | Wanted direction for the match |
| home_arm | input | 4 | Home edge and direction arming |
| wdg_en | input | 1 | Watchdog enable |
| wdg_limit | input | 31 | Watchdog timeout in cycles |
| snap_en | input | 1 | Snapshot enable |
| sw_read | input | 1 | Software read-bank load command |
| flag_clr | input | 4 | Write-1-to-clear flag bits |
| irq_en | input | 4 | Interrupt enables per flag |
| dma_en | input | 4 | DMA request enables per flag |
| trig_en | input | 4 | Trigger enables per flag |
| load_en | input | 4 | Read-bank load enables per flag |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | DMA request pulse |
| trig_out | output | 1 | Trigger pulse |
| read_load | output | 1 | Read-bank load strobe |
| snap_load | output | 1 | Snapshot-bank load strobe |

## Verification
Directed phases hold the phase count on the compare value for many cycles to separate a level match from the edge-qualified flag, and flip revolution count and direction against the two disable bits to show which terms take part. H is toggled under each direction with one arming bit at a time, so a swapped edge or direction bit shows up as a missing or extra home flag. The watchdog is fed with edges and then starved with small limits, telling an off-by-one timeout and a repeated firing apart. A long random phase varies every input and enable together, so clear-versus-set collisions and routing to the four outputs meet in all combinations.

// File: rtl/enc_evt_pkg.sv
package enc_evt_pkg;

    localparam int NUM_EV = 4;

    typedef enum int unsigned {
        EV_INDEX = 0,
        EV_POS   = 1,
        EV_HOME  = 2,
        EV_WDOG  = 3
    } evt_idx_e;

    typedef struct packed {
        logic fall_neg;
        logic fall_pos;
        logic rise_neg;
        logic rise_pos;
    } home_arm_t;

    function automatic logic routed(input logic [NUM_EV-1:0] ev,
                                    input logic [NUM_EV-1:0] en);
        return |(ev & en);
    endfunction

endpackage

// File: rtl/enc_poscmp.sv
module enc_poscmp #(
    parameter int PH_W  = 21,
    parameter int REV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  ph_cnt,
    input  logic [REV_W-1:0] rev_cnt,
    input  logic             dir_in,
    input  logic [PH_W-1:0]  cmp_ph,
    input  logic [REV_W-1:0] cmp_rev,
    input  logic             rev_off,
    input  logic             dir_off,
    input  logic             dir_want,
    output logic             pos_ev
);
    logic ph_hit, rev_hit, dir_hit, match_now, match_q;

    always_comb begin
        ph_hit    = (ph_cnt == cmp_ph);
        rev_hit   = rev_off || (rev_cnt == cmp_rev);
        dir_hit   = dir_off || (dir_in == dir_want);
        match_now = ph_hit && rev_hit && dir_hit;
        pos_ev    = match_now && !match_q;
    end

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= match_now;
    end

    AST_POS_ONCE: assert property (@(posedge clk) disable iff (rst)
        pos_ev |=> !pos_ev) else $error("position event repeated"); // R1

endmodule

// File: rtl/enc_home_det.sv
module enc_home_det
    import enc_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       h_in,
    input  logic       dir_in,
    input  logic [3:0] arm,
    output logic       home_ev
);
    home_arm_t arm_s;
    logic      h_q, h_rise, h_fall;

    always_ff @(posedge clk) h_q <= h_in;

    always_comb begin
        arm_s   = home_arm_t'(arm);
        h_rise  = h_in && !h_q;
        h_fall  = !h_in && h_q;
        home_ev = (h_rise && !dir_in && arm_s.rise_pos) ||
                  (h_rise &&  dir_in && arm_s.rise_neg) ||
                  (h_fall && !dir_in && arm_s.fall_pos) ||
                  (h_fall &&  dir_in && arm_s.fall_neg);
    end

    AST_HOME_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        home_ev |-> !$stable(h_in)) else $error("home event without edge"); // R4

endmodule

// File: rtl/enc_wdog.sv
module enc_wdog #(
    parameter int TO_W = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            edge_seen,
    input  logic [TO_W-1:0] limit,
    output logic            wdg_ev
);
    localparam logic [TO_W-1:0] ONE = TO_W'(1);

    logic [TO_W-1:0] idle_cnt;

    always_comb
        wdg_ev = en && !edge_seen && (limit != '0) && (idle_cnt == limit - ONE);

    always_ff @(posedge clk) begin
        if (rst || !en || edge_seen) idle_cnt <= '0;
        else if (idle_cnt != limit)  idle_cnt <= idle_cnt + ONE;
    end

    AST_WDG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wdg_ev |=> (!wdg_ev || !$stable(limit))) else $error("watchdog refired"); // R5

endmodule

// File: rtl/enc_evt_route.sv
module enc_evt_route
    import enc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev,
    input  logic [NUM_EV-1:0] clr,
    input  logic [NUM_EV-1:0] irq_en,
    input  logic [NUM_EV-1:0] dma_en,
    input  logic [NUM_EV-1:0] trig_en,
    input  logic [NUM_EV-1:0] load_en,
    input  logic              sw_read,
    input  logic              snap_in,
    input  logic              snap_en,
    output logic [NUM_EV-1:0] flags,
    output logic              irq,
    output logic              dma_req,
    output logic              trig_out,
    output logic              read_load,
    output logic              snap_load
);
    logic snap_q;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[g] <= 1'b0;
            else if (ev[g])  flags[g] <= 1'b1;
            else if (clr[g]) flags[g] <= 1'b0;
        end

        AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
            ev[g] |=> flags[g]) else $error("flag not set"); // R6
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            (flags[g] && !clr[g]) |=> flags[g]) else $error("flag lost"); // R6
    end

    always_ff @(posedge clk) snap_q <= snap_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_req   <= 1'b0;
            trig_out  <= 1'b0;
            read_load <= 1'b0;
            snap_load <= 1'b0;
        end else begin
            dma_req   <= routed(ev, dma_en);
            trig_out  <= routed(ev, trig_en);
            read_load <= sw_read || routed(ev, load_en);
            snap_load <= snap_en && snap_in && !snap_q;
        end
    end

    always_comb irq = routed(flags, irq_en);

    AST_SW_READ: assert property (@(posedge clk) disable iff (rst)
        sw_read |=> read_load) else $error("software read lost"); // R9

endmodule

// File: rtl/enc_event_unit.sv
module enc_event_unit
    import enc_evt_pkg::*;
#(
    parameter int PH_W  = 21,
    parameter int REV_W = 32,
    parameter int TO_W  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   ph_cnt,
    input  logic [REV_W-1:0]  rev_cnt,
    input  logic              dir_in,
    input  logic              z_in,
    input  logic              h_in,
    input  logic              edge_strobe,
    input  logic              snap_in,
    input  logic [PH_W-1:0]   cmp_ph,
    input  logic [REV_W-1:0]  cmp_rev,
    input  logic              cmp_rev_off,
    input  logic              cmp_dir_off,
    input  logic              cmp_dir,
    input  logic [3:0]        home_arm,
    input  logic              wdg_en,
    input  logic [TO_W-1:0]   wdg_limit,
    input  logic              snap_en,
    input  logic              sw_read,
    input  logic [NUM_EV-1:0] flag_clr,
    input  logic [NUM_EV-1:0] irq_en,
    input  logic [NUM_EV-1:0] dma_en,
    input  logic [NUM_EV-1:0] trig_en,
    input  logic [NUM_EV-1:0] load_en,
    output logic [NUM_EV-1:0] flags,
    output logic              irq,
    output logic              dma_req,
    output logic              trig_out,
    output logic              read_load,
    output logic              snap_load
);
    logic [NUM_EV-1:0] ev;
    logic z_q, pos_ev, home_ev, wdg_ev;

    always_ff @(posedge clk) z_q <= z_in;

    enc_poscmp #(.PH_W(PH_W), .REV_W(REV_W)) i_poscmp (
        .clk(clk), .rst(rst), .ph_cnt(ph_cnt), .rev_cnt(rev_cnt), .dir_in(dir_in),
        .cmp_ph(cmp_ph), .cmp_rev(cmp_rev), .rev_off(cmp_rev_off),
        .dir_off(cmp_dir_off), .dir_want(cmp_dir), .pos_ev(pos_ev)
    );

    enc_home_det i_home (
        .clk(clk), .rst(rst), .h_in(h_in), .dir_in(dir_in),
        .arm(home_arm), .home_ev(home_ev)
    );

    enc_wdog #(.TO_W(TO_W)) i_wdog (
        .clk(clk), .rst(rst), .en(wdg_en), .edge_seen(edge_strobe),
        .limit(wdg_limit), .wdg_ev(wdg_ev)
    );

    always_comb begin
        ev           = '0;
        ev[EV_INDEX] = z_in && !z_q;
        ev[EV_POS]   = pos_ev;
        ev[EV_HOME]  = home_ev;
        ev[EV_WDOG]  = wdg_ev;
    end

    enc_evt_route i_route (
        .clk(clk), .rst(rst), .ev(ev), .clr(flag_clr), .irq_en(irq_en),
        .dma_en(dma_en), .trig_en(trig_en), .load_en(load_en), .sw_read(sw_read),
        .snap_in(snap_in), .snap_en(snap_en), .flags(flags), .irq(irq),
        .dma_req(dma_req), .trig_out(trig_out), .read_load(read_load),
        .snap_load(snap_load)
    );

    AST_Z_FLAG: assert property (@(posedge clk) disable iff (rst)
        (z_in && !$past(z_in)) |=> flags[EV_INDEX]) else $error("index flag missing"); // R3

endmodule

// File: tb/test_enc_event_unit.sv
`timescale 1ns/1ps
module test_enc_event_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] ph_cnt = '0;
    logic [31:0] rev_cnt = '0;
    logic        dir_in = 0, z_in = 0, h_in = 0, edge_strobe = 0, snap_in = 0;
    logic [20:0] cmp_ph = '0;
    logic [31:0] cmp_rev = '0;
    logic        cmp_rev_off = 0, cmp_dir_off = 0, cmp_dir = 0;
    logic [3:0]  home_arm = '0;
    logic        wdg_en = 0;
    logic [30:0] wdg_limit = '0;
    logic        snap_en = 0, sw_read = 0;
    logic [3:0]  flag_clr = '0, irq_en = '0, dma_en = '0, trig_en = '0, load_en = '0;
    logic [3:0]  flags;
    logic        irq, dma_req, trig_out, read_load, snap_load;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    enc_event_unit i_enc_event_unit (
        .clk(clk), .rst(rst), .ph_cnt(ph_cnt), .rev_cnt(rev_cnt), .dir_in(dir_in),
        .z_in(z_in), .h_in(h_in), .edge_strobe(edge_strobe), .snap_in(snap_in),
        .cmp_ph(cmp_ph), .cmp_rev(cmp_rev), .cmp_rev_off(cmp_rev_off),
        .cmp_dir_off(cmp_dir_off), .cmp_dir(cmp_dir), .home_arm(home_arm),
        .wdg_en(wdg_en), .wdg_limit(wdg_limit), .snap_en(snap_en), .sw_read(sw_read),
        .flag_clr(flag_clr), .irq_en(irq_en), .dma_en(dma_en), .trig_en(trig_en),
        .load_en(load_en), .flags(flags), .irq(irq), .dma_req(dma_req),
        .trig_out(trig_out), .read_load(read_load), .snap_load(snap_load)
    );

    // Behavioural reference model, advanced on every rising edge.
    logic [3:0]  m_flags = '0;
    logic        m_dma = 0, m_trig = 0, m_rl = 0, m_sl = 0;
    logic        m_zq = 0, m_hq = 0, m_sq = 0, m_mq = 0;
    logic [30:0] m_wc = '0;

    always @(posedge clk) begin
        logic [3:0] ev;
        logic match, hr, hf;
        match = (ph_cnt == cmp_ph) && (cmp_rev_off || rev_cnt == cmp_rev)
                && (cmp_dir_off || dir_in == cmp_dir);
        hr = h_in && !m_hq;
        hf = !h_in && m_hq;
        ev[0] = z_in && !m_zq;
        ev[1] = match && !m_mq;
        ev[2] = (hr && !dir_in && home_arm[0]) || (hr && dir_in && home_arm[1]) ||
                (hf && !dir_in && home_arm[2]) || (hf && dir_in && home_arm[3]);
        ev[3] = wdg_en && !edge_strobe && wdg_limit != 0 && m_wc == wdg_limit - 31'd1;
        if (rst) begin
            m_flags = '0; m_dma = 0; m_trig = 0; m_rl = 0; m_sl = 0; m_mq = 0; m_wc = '0;
        end else begin
            m_flags = (m_flags & ~flag_clr) | ev;
            m_dma   = |(ev & dma_en);
            m_trig  = |(ev & trig_en);
            m_rl    = sw_read || |(ev & load_en);
            m_sl    = snap_en && snap_in && !m_sq;
            m_mq    = match;
            if (!wdg_en || edge_strobe) m_wc = '0;
            else if (m_wc != wdg_limit) m_wc = m_wc + 31'd1;
        end
        m_zq = z_in; m_hq = h_in; m_sq = snap_in;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: wait for the edge, compare at the falling edge, return for new inputs.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (rst) begin
            chk("R11 flags", |flags, 1'b0);
            chk("R11 outputs", irq | dma_req | trig_out | read_load | snap_load, 1'b0);
        end else begin
            chk("R3 index flag", flags[0], m_flags[0]);
            chk("R1/R2 position flag", flags[1], m_flags[1]);
            chk("R4 home flag", flags[2], m_flags[2]);
            chk("R5 watchdog flag", flags[3], m_flags[3]);
            chk("R6/R7 irq", irq, |(m_flags & irq_en));
            chk("R8 dma_req", dma_req, m_dma);
            chk("R8 trig_out", trig_out, m_trig);
            chk("R9 read_load", read_load, m_rl);
            chk("R10 snap_load", snap_load, m_sl);
        end
    endtask

    task automatic clear_all();
        flag_clr = 4'hF; step(); flag_clr = 4'h0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) step();
        rst = 0;
        irq_en = 4'hF;
        step();

        // R3 and R6: index edges, clear colliding with a new edge
        z_in = 1; step(); step(); z_in = 0; step();
        flag_clr = 4'h1; z_in = 1; step(); flag_clr = 4'h0; step();
        z_in = 0; flag_clr = 4'h1; step(); flag_clr = 4'h0; step();

        // R1: match held many cycles must set once
        cmp_ph = 21'd7; cmp_rev = 32'd3; rev_cnt = 32'd3; dma_en = 4'h2; trig_en = 4'h2;
        for (int i = 0; i < 12; i++) begin ph_cnt = 21'(i); step(); end
        ph_cnt = 21'd7; repeat (4) step();
        clear_all(); repeat (4) step();
        ph_cnt = 21'd8; step(); ph_cnt = 21'd7; step(); step();

        // R2: revolution and direction terms
        clear_all(); ph_cnt = 21'd0; rev_cnt = 32'd4; step();
        ph_cnt = 21'd7; repeat (2) step();
        cmp_rev_off = 1; repeat (2) step();
        clear_all(); cmp_dir = 1; dir_in = 0; ph_cnt = 21'd1; step(); ph_cnt = 21'd7; step(); step();
        dir_in = 1; step(); step();
        clear_all(); cmp_dir_off = 1; dir_in = 0; ph_cnt = 21'd2; step(); ph_cnt = 21'd7; step(); step();
        cmp_rev_off = 0; cmp_dir_off = 0; cmp_dir = 0;

        // R4: one arming bit at a time, H toggled in both directions
        for (int a = 0; a < 4; a++) begin
            home_arm = 4'(1 << a);
            for (int d = 0; d < 2; d++) begin
                dir_in = d[0];
                clear_all();
                h_in = 1; step(); step();
                h_in = 0; step(); step();
            end
        end
        home_arm = 4'h0;

        // R5: watchdog fed then starved with small limits
        wdg_en = 1; load_en = 4'h8;
        for (int lim = 0; lim < 5; lim++) begin
            wdg_limit = 31'(lim);
            clear_all();
            edge_strobe = 1; step(); edge_strobe = 0;
            repeat (lim + 4) step();
            clear_all(); repeat (3) step();
        end
        wdg_limit = 31'd3;
        for (int i = 0; i < 10; i++) begin edge_strobe = (i % 2 == 0); step(); end
        edge_strobe = 0; wdg_en = 0; repeat (6) step();

        // R9: software read; R10: snap with and without enable
        sw_read = 1; step(); sw_read = 0; step();
        snap_in = 1; step(); snap_in = 0; step();
        snap_en = 1; snap_in = 1; step(); step(); snap_in = 0; step();

        // R6, R7, R8, R9, R10: random mix of every input and enable
        for (int blk = 0; blk < 60; blk++) begin
            irq_en = 4'($urandom); dma_en = 4'($urandom); trig_en = 4'($urandom);
            load_en = 4'($urandom); home_arm = 4'($urandom);
            cmp_ph = 21'($urandom_range(0, 7)); cmp_rev = 32'($urandom_range(0, 1));
            cmp_rev_off = 1'($urandom); cmp_dir_off = 1'($urandom); cmp_dir = 1'($urandom);
            snap_en = 1'($urandom); wdg_en = 1'($urandom);
            edge_strobe = 1;
            wdg_limit = 31'($urandom_range(0, 8));
            step();
            for (int c = 0; c < 40; c++) begin
                ph_cnt = 21'($urandom_range(0, 7)); rev_cnt = 32'($urandom_range(0, 1));
                dir_in = 1'($urandom); z_in = 1'($urandom); h_in = 1'($urandom);
                edge_strobe = ($urandom_range(0, 9) == 0); snap_in = 1'($urandom);
                sw_read = ($urandom_range(0, 7) == 0);
                flag_clr = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
                step();
            end
        end
        flag_clr = '0; sw_read = 0;

        // R11: reset again clears everything
        rst = 1; step(); step(); rst = 0; step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule